// File: doc/BRIEF.md
# Infrared Pulse Interval Capture Timer

This block measures the time between edges of a demodulated infrared signal, so that firmware can learn the pulse and space timing of a remote-control code. A free-running up counter advances on a prescaled tick. On each selected edge of the (optionally inverted) input, the running count is copied into a capture register and the counter restarts from zero. Each captured value is therefore the length of the interval that has just ended.

If no edge arrives before the counter passes its largest value, the block raises a one-cycle overflow interrupt. By default the counter then wraps to zero and keeps counting. In hold mode it stops at its terminal value until the next clear or capture. A second, independent interrupt reports edges on the conditioned input, with the edge type chosen by a 2-bit select. A synchronous clear control sets the counter and the capture register back to their initial values.

The IR input is expected to be synchronous to `clk`; any synchroniser sits outside the block. All outputs are registered.

Top module: `ir_interval_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `cnt_q` is 0, `cap_q` is all ones, and both `ovf_irq` and `edge_irq` are 0.
- R2: While `en` is 1, `cnt_q` increases by one on every tick. While `en` is 0, `cnt_q` holds its value and no capture takes place.
- R3: `clk_sel` sets the tick rate: 00 gives every clock, 01 every 2nd, 10 every 4th and 11 every 8th clock. The tick divider restarts whenever `en` is 0, on a capture and on a clear, so the first tick after a restart comes 2^`clk_sel` clocks later.
- R4: A capture edge is a rising edge of the conditioned input when `cap_both` is 0, and either edge when `cap_both` is 1. At the clock edge where `en` is 1 and a capture edge is seen, `cap_q` takes the value `cnt_q` had before that edge and `cnt_q` becomes 0.
- R5: When a tick arrives while `cnt_q` is at its largest value (all ones), `ovf_irq` is 1 for exactly the next cycle. With `ovf_hold` at 0, `cnt_q` wraps to 0 at the same edge.
- R6: With `ovf_hold` at 1, an overflow leaves `cnt_q` at all ones. Further ticks neither change it nor raise `ovf_irq` again until a clear or a capture.
- R7: While `clr` is 1, the next clock edge sets `cnt_q` to 0 and `cap_q` to all ones. A clear takes priority over a capture at the same edge.
- R8: `eint_sel` chooses the edge interrupt: 00 none, 01 falling, 10 rising, 11 both edges of the conditioned input. `edge_irq` pulses for one cycle, the cycle after the edge, whatever the value of `en`.
- R9: With `inv_pol` at 1, the input is inverted before both the capture and the edge-interrupt detection. A low-going pin edge then counts as rising. The stored previous input level resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Counting and capture enable |
| clr | input | 1 | Clear counter to 0 and capture register to all ones |
| clk_sel | input | 2 | Tick rate: 1, 1/2, 1/4, 1/8 of the clock |
| ir_in | input | 1 | Demodulated IR input, synchronous to clk |
| inv_pol | input | 1 | Invert the IR input before edge detection |
| cap_both | input | 1 | 0: capture on rising edges, 1: on both edges |
| ovf_hold | input | 1 | 0: wrap on overflow, 1: stop at all ones |
| eint_sel | input | 2 | Edge interrupt: 00 off, 01 falling, 10 rising, 11 both |
| cnt_q | output | CNT_W | Running interval counter |
| cap_q | output | CNT_W | Last captured interval |
| ovf_irq | output | 1 | One-cycle overflow interrupt |
| edge_irq | output | 1 | One-cycle IR edge interrupt |

## Verification
The bench builds the timer with `CNT_W` set to 8 instead of 14. This brings wrap-around, repeated overflow and hold-at-all-ones within a few hundred ticks, even at the slowest tick rate, while the rest of the logic stays the same. The divider width follows the 2-bit tick select, so all four rates, including divider restarts on capture and on disable, are covered unchanged. A clear and a capture edge are applied together to reach their priority order. An inverted-input section runs every edge-interrupt select against both input polarities.

// File: rtl/ir_timer_pkg.sv
// Package: shared types and helpers for the IR interval capture timer.
// Assumes a 2-bit edge-interrupt select and a power-of-two tick divider.
package ir_timer_pkg;

    typedef enum logic [1:0] {
        EINT_OFF  = 2'b00,
        EINT_FALL = 2'b01,
        EINT_RISE = 2'b10,
        EINT_BOTH = 2'b11
    } eint_mode_e;

    // Low-bit mask whose all-ones state marks a tick for a divide by 2^sel.
    function automatic logic [2:0] tick_mask(input logic [1:0] sel);
        logic [2:0] m;
        m = 3'b000;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ir_edge_detect.sv
// Edge detector: conditions the IR input by the polarity bit, finds rising
// and falling edges against the stored previous level, and produces the
// capture strobe and the registered edge interrupt.
// Assumes ir_in is already synchronous to clk.
module ir_edge_detect
    import ir_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_in,
    input  logic       inv_pol,
    input  logic       cap_both,
    input  logic [1:0] eint_sel,
    output logic       cap_evt,
    output logic       edge_irq
);

    logic       lvl;
    logic       lvl_d;
    logic       rise;
    logic       fall;
    logic       irq_hit;
    eint_mode_e mode;

    // Condition the input and classify the edge in this cycle.
    always_comb begin
        lvl     = ir_in ^ inv_pol;
        rise    = lvl & ~lvl_d;
        fall    = ~lvl & lvl_d;
        cap_evt = rise | (cap_both & fall);
        mode    = eint_mode_e'(eint_sel);
        unique case (mode)
            EINT_FALL: irq_hit = fall;
            EINT_RISE: irq_hit = rise;
            EINT_BOTH: irq_hit = rise | fall;
            default:   irq_hit = 1'b0;
        endcase
    end

    // Store the previous conditioned level and register the edge interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d    <= 1'b0;
            edge_irq <= 1'b0;
        end else begin
            lvl_d    <= lvl;
            edge_irq <= irq_hit;
        end
    end

    // R8: with the interrupt switched off, no edge interrupt follows
    a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (eint_sel == 2'b00) |=> !edge_irq);

    // R8: an edge interrupt is always a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        edge_irq |=> !edge_irq || (lvl_d != $past(lvl_d)));

endmodule

// File: rtl/ir_tick_gen.sv
// Tick generator: a small free-running divider that yields a tick every
// 1, 2, 4 or 8 clocks according to clk_sel. It restarts from zero on
// request, so the first tick after a restart comes a full period later.
module ir_tick_gen
    import ir_timer_pkg::*;
#(
    parameter int SEL_W = 2,
    localparam int DIV_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Decode the divide ratio and flag the tick cycle.
    always_comb begin
        mask = DIV_W'(tick_mask(2'(clk_sel)));
        tick = ((div_q & mask) == mask);
    end

    // Advance the divider, or restart it.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R3: at the slowest rate two ticks never fall in adjacent cycles
    a_r3_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == SEL_W'(3) && tick && !restart) |=> (!tick || clk_sel != SEL_W'(3)));

endmodule

// File: rtl/ir_interval_counter.sv
// Interval counter: counts ticks, latches the count and restarts on each
// capture, flags overflow, and either wraps or holds at all ones.
// Assumes cap_evt and tick are single-cycle strobes from the same clock.
module ir_interval_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             cap_evt,
    input  logic             clr,
    input  logic             ovf_hold,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cap_q,
    output logic             ovf_irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic cap_ok;
    logic at_max;
    logic sat_q;

    // Qualify the capture with the enable and spot the terminal count.
    always_comb begin
        cap_ok = en & cap_evt;
        at_max = (cnt_q == CNT_MAX);
    end

    // Count, capture, clear and overflow handling, clear first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cap_q   <= CNT_MAX;
            ovf_irq <= 1'b0;
            sat_q   <= 1'b0;
        end else begin
            ovf_irq <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
                cap_q <= CNT_MAX;
                sat_q <= 1'b0;
            end else if (cap_ok) begin
                cap_q <= cnt_q;
                cnt_q <= '0;
                sat_q <= 1'b0;
            end else if (en && tick) begin
                if (at_max) begin
                    if (ovf_hold) begin
                        ovf_irq <= ~sat_q;
                        sat_q   <= 1'b1;
                    end else begin
                        ovf_irq <= 1'b1;
                        cnt_q   <= '0;
                        sat_q   <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R4: a capture latches the previous count and restarts the counter
    a_r4_capture_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ok && !clr) |=> (cnt_q == '0 && cap_q == $past(cnt_q)));

    // R5: an overflow pulse only follows a counter sitting at all ones
    a_r5_ovf_from_max: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ($past(cnt_q) == CNT_MAX));

    // R6: once saturated in hold mode, the counter stays and stays quiet
    a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_q && ovf_hold && !clr && !cap_ok) |=> (cnt_q == CNT_MAX && !ovf_irq));

    // R7: a clear leaves the counter at zero and the capture at all ones
    a_r7_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && cap_q == CNT_MAX && !ovf_irq));

    // R2: without the enable the count does not move
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/ir_interval_timer.sv
// Top level of the IR interval capture timer: joins the edge detector,
// the tick generator and the interval counter. The tick divider restarts
// while disabled, on a capture and on a clear so intervals count exactly.
// Assumes ir_in is synchronous to clk; all outputs are registered.
module ir_interval_timer #(
    parameter int CNT_W = 14,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             ir_in,
    input  logic             inv_pol,
    input  logic             cap_both,
    input  logic             ovf_hold,
    input  logic [1:0]       eint_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cap_q,
    output logic             ovf_irq,
    output logic             edge_irq
);

    logic cap_evt;
    logic tick;
    logic tick_restart;

    // Restart the divider whenever the counter is cleared or idle.
    always_comb begin
        tick_restart = clr | ~en | cap_evt;
    end

    ir_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir_in    (ir_in),
        .inv_pol  (inv_pol),
        .cap_both (cap_both),
        .eint_sel (eint_sel),
        .cap_evt  (cap_evt),
        .edge_irq (edge_irq)
    );

    ir_tick_gen #(
        .SEL_W (SEL_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tick_restart),
        .clk_sel (clk_sel),
        .tick    (tick)
    );

    ir_interval_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .cap_evt  (cap_evt),
        .clr      (clr),
        .ovf_hold (ovf_hold),
        .cnt_q    (cnt_q),
        .cap_q    (cap_q),
        .ovf_irq  (ovf_irq)
    );

    // R1: the reset leaves both interrupts low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ovf_irq && !edge_irq && cnt_q == '0));

endmodule

// File: tb/tb_ir_interval_timer.sv
module tb_ir_interval_timer;

    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         clr = 1'b0;
    logic [1:0]   clk_sel = 2'b00;
    logic         ir_in = 1'b0;
    logic         inv_pol = 1'b0;
    logic         cap_both = 1'b0;
    logic         ovf_hold = 1'b0;
    logic [1:0]   eint_sel = 2'b00;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cap_q;
    logic         ovf_irq;
    logic         edge_irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string tag = "R1";

    // behavioural reference state
    int m_cnt = 0, m_cap = MAX, m_pd = 0;
    bit m_sat = 0, m_oirq = 0, m_eirq = 0, m_prev = 0;
    int ovf_seen = 0, ovf_model = 0, eirq_seen = 0;

    ir_interval_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .clk_sel(clk_sel),
        .ir_in(ir_in), .inv_pol(inv_pol), .cap_both(cap_both),
        .ovf_hold(ovf_hold), .eint_sel(eint_sel), .cnt_q(cnt_q),
        .cap_q(cap_q), .ovf_irq(ovf_irq), .edge_irq(edge_irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    // reference model, advanced at every rising edge from the sampled inputs
    always @(posedge clk) begin
        bit s, rise, fall, capev, tk;
        int per;
        s    = ir_in ^ inv_pol;
        rise = s && !m_prev;
        fall = !s && m_prev;
        if (!rst_n) begin
            m_cnt = 0; m_cap = MAX; m_pd = 0; m_sat = 0;
            m_oirq = 0; m_eirq = 0; m_prev = 0;
        end else begin
            case (eint_sel)
                2'b01: m_eirq = fall;
                2'b10: m_eirq = rise;
                2'b11: m_eirq = rise || fall;
                default: m_eirq = 0;
            endcase
            capev  = en && (rise || (cap_both && fall));
            m_oirq = 0;
            if (clr) begin
                m_cnt = 0; m_cap = MAX; m_pd = 0; m_sat = 0;
            end else if (capev) begin
                m_cap = m_cnt; m_cnt = 0; m_pd = 0; m_sat = 0;
            end else if (!en) begin
                m_pd = 0;
            end else begin
                per  = 1 << clk_sel;
                tk   = (m_pd % per) == per - 1;
                m_pd = (m_pd + 1) % 8;
                if (tk) begin
                    if (m_cnt == MAX) begin
                        if (ovf_hold) begin
                            if (!m_sat) m_oirq = 1;
                            m_sat = 1;
                        end else begin
                            m_oirq = 1; m_cnt = 0; m_sat = 0;
                        end
                    end else begin
                        m_cnt++;
                    end
                end
            end
            if (m_oirq) ovf_model++;
            m_prev = s;
        end
    end

    // compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(tag, "cnt_q", int'(cnt_q), m_cnt);
            chk(tag, "cap_q", int'(cap_q), m_cap);
            chk(tag, "ovf_irq", int'(ovf_irq), int'(m_oirq));
            chk(tag, "edge_irq", int'(edge_irq), int'(m_eirq));
            if (ovf_irq) ovf_seen++;
            if (edge_irq) eirq_seen++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_ir(input int gap, input int times);
        for (int i = 0; i < times; i++) begin
            step(gap + i);
            ir_in = ~ir_in;
        end
    endtask

    initial begin
        step(4);
        // R1: reset state
        tag = "R1";
        chk("R1", "cnt_q reset", int'(cnt_q), 0);
        chk("R1", "cap_q reset", int'(cap_q), MAX);
        chk("R1", "ovf_irq reset", int'(ovf_irq), 0);
        chk("R1", "edge_irq reset", int'(edge_irq), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R2: count every clock, then freeze with the enable low
        tag = "R2";
        en = 1'b1; step(20);
        chk("R2", "count after 20 clocks", int'(cnt_q), 20);
        en = 1'b0; step(6);
        chk("R2", "count held while off", int'(cnt_q), 20);

        // R3: each tick rate
        tag = "R3";
        for (int s = 0; s < 4; s++) begin
            clr = 1'b1; step(1); clr = 1'b0;
            clk_sel = 2'(s); en = 1'b1; step(16);
            chk("R3", "ticks in 16 clocks", int'(cnt_q), 16 >> s);
            en = 1'b0; step(3); en = 1'b1; step(5);
        end
        clk_sel = 2'b00;

        // R4: rising-only then both-edge capture
        tag = "R4";
        clr = 1'b1; step(1); clr = 1'b0;
        cap_both = 1'b0; toggle_ir(7, 6);
        step(3);
        chk("R4", "rising-only capture", int'(cap_q), m_cap);
        cap_both = 1'b1; clk_sel = 2'b01; toggle_ir(5, 6);
        step(2);
        chk("R4", "both-edge capture", int'(cap_q), m_cap);
        en = 1'b0; toggle_ir(3, 2); en = 1'b1; clk_sel = 2'b00;
        step(2);

        // R5: wrap-around overflow
        tag = "R5";
        ovf_hold = 1'b0; clr = 1'b1; step(1); clr = 1'b0;
        step(MAX + 1);
        chk("R5", "count after wrap", int'(cnt_q), 0);
        step(2 * (MAX + 1));
        clk_sel = 2'b11; step(8 * (MAX + 1) + 20);
        chk("R5", "overflow pulses seen", ovf_seen, ovf_model);
        chk("R5", "at least three overflows", int'(ovf_seen >= 3), 1);
        clk_sel = 2'b00;

        // R6: hold at all ones
        tag = "R6";
        ovf_hold = 1'b1; clr = 1'b1; step(1); clr = 1'b0;
        step(3 * (MAX + 1));
        chk("R6", "count held at top", int'(cnt_q), MAX);
        chk("R6", "single overflow in hold", ovf_seen, ovf_model);
        ir_in = ~ir_in; step(2);
        chk("R6", "capture releases hold", int'(cap_q), MAX);
        ovf_hold = 1'b0;

        // R7: clear wins over a simultaneous capture
        tag = "R7";
        step(10);
        clr = 1'b1; ir_in = ~ir_in; step(1); clr = 1'b0;
        chk("R7", "cap_q after clear+edge", int'(cap_q), MAX);
        chk("R7", "cnt_q after clear+edge", int'(cnt_q), 0);

        // R8: every edge-interrupt select, enabled and disabled
        tag = "R8";
        for (int s = 0; s < 4; s++) begin
            eint_sel = 2'(s);
            toggle_ir(2, 4);
            en = 1'b0; toggle_ir(2, 2); en = 1'b1;
        end
        step(2);
        chk("R8", "edge interrupts seen", int'(eirq_seen > 0), 1);

        // R9: inverted polarity
        tag = "R9";
        inv_pol = 1'b1; step(2);
        cap_both = 1'b0;
        for (int s = 0; s < 4; s++) begin
            eint_sel = 2'(s);
            toggle_ir(3, 4);
        end
        step(2);
        chk("R9", "inverted-input capture", int'(cap_q), m_cap);

        step(4);
        cmp_on = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule